// File: doc/BRIEF.md
# Digital Volume Soft-Ramp Controller

This block computes the digital gain applied to one audio channel. When the channel is brought up, it moves the gain from a muted floor of -100 dB toward the programmed volume. It moves in 0.5 dB increments, one increment per audio frame. When the channel is taken down, it walks the gain back to the floor the same way. A frame strobe marks each sample period, so a ramp lasts a fixed number of frames and its length in time falls as the sample rate rises.

The block never stalls or gates sample traffic. Samples keep flowing while the ramp runs and are only attenuated by the current gain. A power-down ramp starts at once and overlaps whatever shutdown sequencing happens around the block; it is not queued behind it. Clearing the ramp enable turns the ramp off: the gain then jumps straight to its goal. The multiplier, the dB-to-linear table and any control interface sit outside this block.

Top module: `vol_soft_ramp`

## Requirements
- R1: After a synchronous reset, the block is in the powered-down state. `gain_code` reads -200 and `ramp_done` is 1.
- R2: Gain codes are signed 9-bit counts of 0.5 dB, so -200 means -100 dB and 0 means 0 dB. The requested target is limited to the range -200..+80 before use, and `gain_code` never leaves that range.
- R3: A power-up request accepted with the ramp enabled sets `gain_code` to -200 on the next cycle. A frame strobe in the accepting cycle produces no step.
- R4: With the ramp enabled and no request pending, each frame strobe moves `gain_code` by exactly one code toward its goal. Without a strobe the gain holds. A ramp from -200 to a target T therefore takes T+200 frames.
- R5: If the target changes while powered up with the ramp enabled, the gain steps one code per frame toward the new clamped target, in either direction.
- R6: With the ramp disabled, the gain equals the clamped target one cycle after a power-up request or a target change. It equals -200 one cycle after a power-down request. While powered down, target changes leave the gain at -200.
- R7: A power-down request with the ramp enabled takes no step in its own cycle. From the next strobe on, the gain steps down one code per frame from its current value, even if the up-ramp has not finished, until it reaches -200.
- R8: `ramp_done` is 1 exactly when `gain_code` equals the goal. The goal is the clamped target while powered up and -200 while powered down.
- R9: If power-up and power-down requests arrive in the same cycle, the power-down request wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| ramp_en | input | 1 | 1 = soft ramp active, 0 = gain jumps to its goal |
| target_gain | input | 9 | Signed programmed volume in 0.5 dB codes |
| pwr_up_req | input | 1 | One-cycle request to bring the channel up |
| pwr_dn_req | input | 1 | One-cycle request to take the channel down |
| gain_code | output | 9 | Signed applied gain in 0.5 dB codes (registered) |
| ramp_done | output | 1 | Gain has reached its goal |

## Verification
Every result settles one clock edge after its cause. A request, a target change or a frame strobe driven before an edge shows its effect on `gain_code` and `ramp_done` after that edge. The bench changes inputs at the falling edge, lets one rising edge pass, and reads outputs at the following falling edge. Strobes are spaced with an idle cycle, so each check lines up with a known count of frames. The registered target adds one more cycle before a new goal governs stepping. For that reason, every target change is followed by an idle cycle before the next strobe.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic {
    MODE_FALL = 1'b0,
    MODE_RISE = 1'b1
  } ramp_mode_e;
endpackage

// File: rtl/vsr_target_clamp.sv
module vsr_target_clamp #(
  parameter int GAIN_W   = 9,
  parameter int MIN_CODE = -200,
  parameter int MAX_CODE = 80
) (
  input  logic signed [GAIN_W-1:0] raw_code,
  output logic signed [GAIN_W-1:0] lim_code
);
  localparam logic signed [GAIN_W-1:0] MIN_V = GAIN_W'(MIN_CODE);
  localparam logic signed [GAIN_W-1:0] MAX_V = GAIN_W'(MAX_CODE);

  always_comb begin
    if (raw_code < MIN_V)      lim_code = MIN_V;
    else if (raw_code > MAX_V) lim_code = MAX_V;
    else                       lim_code = raw_code;
  end
endmodule

// File: rtl/vsr_mode_ctrl.sv
module vsr_mode_ctrl
  import vsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       up_req,
  input  logic       dn_req,
  output ramp_mode_e mode_q,
  output logic       up_acc,
  output logic       dn_acc
);
  // shutdown has priority over wake-up
  assign dn_acc = dn_req;
  assign up_acc = up_req & ~dn_req;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_FALL;
    else if (dn_acc) mode_q <= MODE_FALL;
    else if (up_acc) mode_q <= MODE_RISE;
  end
endmodule

// File: rtl/vsr_gain_stepper.sv
module vsr_gain_stepper
  import vsr_pkg::*;
#(
  parameter int GAIN_W    = 9,
  parameter int MUTE_CODE = -200
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ramp_en,
  input  logic                     frame_stb,
  input  logic                     up_acc,
  input  logic                     dn_acc,
  input  ramp_mode_e               mode_q,
  input  logic signed [GAIN_W-1:0] tgt_lim,
  output logic signed [GAIN_W-1:0] gain_q,
  output logic                     at_goal
);
  localparam logic signed [GAIN_W-1:0] MUTE_V = GAIN_W'(MUTE_CODE);
  localparam logic signed [GAIN_W-1:0] ONE_V  = GAIN_W'(1);

  logic signed [GAIN_W-1:0] tgt_q;
  logic signed [GAIN_W-1:0] goal;
  logic signed [GAIN_W-1:0] stepped;

  assign goal = (mode_q == MODE_RISE) ? tgt_q : MUTE_V;

  always_comb begin
    if (gain_q < goal)      stepped = gain_q + ONE_V;
    else if (gain_q > goal) stepped = gain_q - ONE_V;
    else                    stepped = gain_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= MUTE_V;
      gain_q <= MUTE_V;
    end else begin
      tgt_q <= tgt_lim;
      if (dn_acc)
        gain_q <= ramp_en ? gain_q : MUTE_V;
      else if (up_acc)
        gain_q <= ramp_en ? MUTE_V : tgt_lim;
      else if (!ramp_en)
        gain_q <= (mode_q == MODE_RISE) ? tgt_lim : MUTE_V;
      else if (frame_stb)
        gain_q <= stepped;
    end
  end

  assign at_goal = (gain_q == goal);
endmodule

// File: rtl/vol_soft_ramp.sv
module vol_soft_ramp
  import vsr_pkg::*;
#(
  parameter int GAIN_W    = 9,
  parameter int MUTE_CODE = -200,
  parameter int MAX_CODE  = 80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_stb,
  input  logic                     ramp_en,
  input  logic signed [GAIN_W-1:0] target_gain,
  input  logic                     pwr_up_req,
  input  logic                     pwr_dn_req,
  output logic signed [GAIN_W-1:0] gain_code,
  output logic                     ramp_done
);
  logic signed [GAIN_W-1:0] tgt_lim;
  ramp_mode_e               mode_q;
  logic                     up_acc;
  logic                     dn_acc;

  vsr_target_clamp #(
    .GAIN_W(GAIN_W), .MIN_CODE(MUTE_CODE), .MAX_CODE(MAX_CODE)
  ) u_clamp (
    .raw_code(target_gain),
    .lim_code(tgt_lim)
  );

  vsr_mode_ctrl u_mode (
    .clk(clk), .rst(rst),
    .up_req(pwr_up_req), .dn_req(pwr_dn_req),
    .mode_q(mode_q), .up_acc(up_acc), .dn_acc(dn_acc)
  );

  vsr_gain_stepper #(
    .GAIN_W(GAIN_W), .MUTE_CODE(MUTE_CODE)
  ) u_step (
    .clk(clk), .rst(rst),
    .ramp_en(ramp_en), .frame_stb(frame_stb),
    .up_acc(up_acc), .dn_acc(dn_acc), .mode_q(mode_q),
    .tgt_lim(tgt_lim),
    .gain_q(gain_code), .at_goal(ramp_done)
  );
endmodule

// File: rtl/vsr_chk.sv
module vsr_chk #(
  parameter int GAIN_W    = 9,
  parameter int MUTE_CODE = -200,
  parameter int MAX_CODE  = 80
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     frame_stb,
  input logic                     ramp_en,
  input logic signed [GAIN_W-1:0] target_gain,
  input logic                     pwr_up_req,
  input logic                     pwr_dn_req,
  input logic signed [GAIN_W-1:0] gain_code
);
  localparam logic signed [GAIN_W-1:0] MUTE_V = GAIN_W'(MUTE_CODE);
  localparam logic signed [GAIN_W-1:0] MAX_V  = GAIN_W'(MAX_CODE);
  localparam logic signed [GAIN_W-1:0] ONE_V  = GAIN_W'(1);

  // R2
  gain_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (gain_code >= MUTE_V) && (gain_code <= MAX_V));

  // R3
  rise_starts_muted_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_en && pwr_up_req && !pwr_dn_req) |=> (gain_code == MUTE_V));

  // R4
  hold_without_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_en && !frame_stb && !pwr_up_req && !pwr_dn_req) |=> $stable(gain_code));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_en && frame_stb && !pwr_up_req && !pwr_dn_req) |=>
      ((gain_code == $past(gain_code)) ||
       (gain_code == $past(gain_code) + ONE_V) ||
       (gain_code == $past(gain_code) - ONE_V)));

  // R7
  fall_no_step_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_en && pwr_dn_req) |=> $stable(gain_code));

  // R6
  bypass_fall_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (!ramp_en && pwr_dn_req) |=> (gain_code == MUTE_V));

  // R2
  bypass_clamp_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!ramp_en && pwr_up_req && !pwr_dn_req && (target_gain > MAX_V)) |=>
      (gain_code == MAX_V));
endmodule

bind vol_soft_ramp vsr_chk #(
  .GAIN_W(GAIN_W), .MUTE_CODE(MUTE_CODE), .MAX_CODE(MAX_CODE)
) u_vsr_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .ramp_en(ramp_en),
  .target_gain(target_gain), .pwr_up_req(pwr_up_req),
  .pwr_dn_req(pwr_dn_req), .gain_code(gain_code)
);

// File: tb/tb_vol_soft_ramp.sv
module tb_vol_soft_ramp;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frame_stb = 1'b0;
  logic              ramp_en = 1'b0;
  logic signed [8:0] target_gain = '0;
  logic              pwr_up_req = 1'b0;
  logic              pwr_dn_req = 1'b0;
  logic signed [8:0] gain_code;
  logic              ramp_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vol_soft_ramp dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .ramp_en(ramp_en),
    .target_gain(target_gain), .pwr_up_req(pwr_up_req),
    .pwr_dn_req(pwr_dn_req), .gain_code(gain_code), .ramp_done(ramp_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int g, input int d);
    chk({req, " gain"}, int'(gain_code), g);
    chk({req, " done"}, int'(ramp_done), d);
  endtask

  // one rising edge, then sample at the falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_stb = 1'b1;
      cycle();
      frame_stb = 1'b0;
      cycle();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) cycle();
    rst = 1'b0;
    cycle();
    chk_out("R1 reset", -200, 1);
  endtask

  task automatic t_bypass();
    ramp_en = 1'b0;
    target_gain = 9'sd40;
    pwr_up_req = 1'b1;
    cycle();
    pwr_up_req = 1'b0;
    chk_out("R6 bypass rise", 40, 1);
    target_gain = -9'sd10;
    cycle();
    chk_out("R6 bypass follow", -10, 1);
    target_gain = 9'sd100;
    cycle();
    chk_out("R2 clamp top", 80, 1);
    target_gain = -9'sd256;
    cycle();
    chk_out("R2 clamp bottom", -200, 1);
    target_gain = 9'sd40;
    cycle();
    pwr_dn_req = 1'b1;
    cycle();
    pwr_dn_req = 1'b0;
    chk_out("R6 bypass fall", -200, 1);
    target_gain = 9'sd20;
    cycle();
    chk_out("R6 target ignored when down", -200, 1);
  endtask

  task automatic t_ramp_up();
    ramp_en = 1'b1;
    target_gain = 9'sd0;
    pwr_up_req = 1'b1;
    frame_stb = 1'b1;
    cycle();
    pwr_up_req = 1'b0;
    frame_stb = 1'b0;
    chk_out("R3 accept no step", -200, 0);
    cycle();
    frames(1);
    chk_out("R4 first step", -199, 0);
    repeat (5) cycle();
    chk_out("R4 hold without strobe", -199, 0);
    frames(198);
    chk_out("R8 one short of goal", -1, 0);
    frames(1);
    chk_out("R4 reach 0 dB after 200 frames", 0, 1);
    frames(3);
    chk_out("R8 stays at goal", 0, 1);
  endtask

  task automatic t_retarget();
    pwr_up_req = 1'b1;
    cycle();
    pwr_up_req = 1'b0;
    chk_out("R3 restart from mute", -200, 0);
    frames(50);
    chk_out("R4 partial ramp", -150, 0);
    target_gain = -9'sd160;
    cycle();
    frames(10);
    chk_out("R5 retarget downward", -160, 1);
    target_gain = -9'sd155;
    cycle();
    frames(4);
    chk_out("R5 retarget upward partial", -156, 0);
    frames(1);
    chk_out("R5 retarget upward done", -155, 1);
    target_gain = 9'sd0;
    cycle();
    chk_out("R8 new target not reached", -155, 0);
  endtask

  task automatic t_ramp_down();
    pwr_dn_req = 1'b1;
    frame_stb = 1'b1;
    cycle();
    pwr_dn_req = 1'b0;
    frame_stb = 1'b0;
    chk_out("R7 accept no step", -155, 0);
    frames(1);
    chk_out("R7 falls from current gain", -156, 0);
    frames(43);
    chk_out("R7 near floor", -199, 0);
    frames(1);
    chk_out("R7 floor reached", -200, 1);
    frames(2);
    chk_out("R7 stays at floor", -200, 1);
  endtask

  task automatic t_priority();
    target_gain = 9'sd20;
    pwr_up_req = 1'b1;
    pwr_dn_req = 1'b1;
    cycle();
    pwr_up_req = 1'b0;
    pwr_dn_req = 1'b0;
    chk_out("R9 down wins", -200, 1);
    frames(2);
    chk_out("R9 no rise after tie", -200, 1);
  endtask

  task automatic t_disable_mid();
    pwr_up_req = 1'b1;
    cycle();
    pwr_up_req = 1'b0;
    frames(10);
    chk_out("R4 ten frames", -190, 0);
    ramp_en = 1'b0;
    cycle();
    chk_out("R6 disable mid ramp", 20, 1);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_bypass();
    t_ramp_up();
    t_retarget();
    t_ramp_down();
    t_priority();
    t_disable_mid();
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule